// File: doc/BRIEF.md
# Coprocessor Host Mailbox

This block sits between a host bus and a measurement coprocessor core. The host sees two byte-wide addresses. At the first address it writes command bytes and reads result bytes. At the second address it reads a status byte and writes to a reset-trigger port. The block runs the single-byte handshake in both directions and holds a sticky alarm flag fed by the channel limit checks. A write of any value to the trigger port resets the whole block. After every reset a fault flag stays high for a programmable number of cycles.

On the core side a command byte is offered with a valid strobe and taken with a ready strobe. A result byte is pushed with a valid strobe whenever the block shows ready. The alarm flag is set by a violation strobe and cleared by a strobe that marks completion of the alarm-readout command. While the fault flag is high, the three handshake flags read as zero, so the host waits for fault to drop before it starts talking to the core.

Top module: `cop_mailbox`

## Requirements
- R1: The status byte is bit0 command-empty, bit1 data-available, bit2 alarm, bit3 fault, and bits 7:4 always read 0. Hard reset (`rst_n` low) clears the command slot, the result slot, the alarm and the overrun flag. While reset is active the status reads 0x08.
- R2: `rst_n` passes through a two-stage synchronizer. Fault first reads 0 at the (FAULT_CYCLES+2)-th rising edge after `rst_n` is released. `fault_led` always equals the status fault bit.
- R3: A host write with `host_addr`=1 starts a soft reset whatever its data. The soft reset clears the same state as R1. Fault is 1 from the edge that takes the write and first reads 0 at the (FAULT_CYCLES+2)-th edge after it.
- R4: With `host_addr`=0, a host write while command-empty reads 1 stores the byte, drives `cmd_valid` with it, and makes command-empty read 0. The byte stays offered until an edge that sees `cmd_valid` and `cmd_ready` both high, after which command-empty reads 1 again.
- R5: `res_ready` is high when no unread result is held. A result taken on `res_valid` sets data-available and blocks further results. A host read with `host_addr`=0 returns the byte and clears data-available.
- R6: Alarm is set by `alarm_hit` and stays set until an `alarm_clear` cycle with no `alarm_hit` in that cycle. Status reads do not clear it.
- R7: While fault is 1, including while `fault_in` is high, status bits 2:0 read 0. The underlying flags are kept and reappear when fault drops.
- R8: A command write while command-empty reads 0 is dropped: the offered byte is unchanged. The write sets the sticky `overrun` output, which only a reset clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| host_addr | input | 1 | 0: command/data, 1: reset trigger/status |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (clears data-available at address 0) |
| host_wdata | input | DATA_W | Host write byte |
| host_rdata | output | DATA_W | Result byte or status byte, selected by address |
| cmd_valid | output | 1 | Command byte offered to core |
| cmd_byte | output | DATA_W | Offered command byte |
| cmd_ready | input | 1 | Core takes the command byte |
| res_valid | input | 1 | Core pushes a result byte |
| res_byte | input | DATA_W | Result byte from core |
| res_ready | output | 1 | Result slot is free |
| alarm_hit | input | 1 | Channel limit violation strobe |
| alarm_clear | input | 1 | Alarm readout command executed |
| fault_in | input | 1 | External fault condition |
| fault_led | output | 1 | Mirrors the status fault bit |
| overrun | output | 1 | Sticky dropped-command flag |

## Verification
The bench counts the exact length of the fault window after both reset kinds. A design off by a synchronizer stage or a counter load would report fault one cycle early or late. It holds a command without ready to catch a slot that lets go too soon, and it writes a second command into a full slot: a design without the drop would overwrite the pending byte or fail to flag overrun. It fires violation and clear in the same cycle, where a wrong priority loses the alarm. It also raises `fault_in` over live flags, where a design that clears instead of masks would lose the stored result and alarm.

// File: rtl/cop_mailbox_pkg.sv
package cop_mailbox_pkg;
  localparam int ST_CRMT  = 0;
  localparam int ST_DAV   = 1;
  localparam int ST_ALARM = 2;
  localparam int ST_FAULT = 3;
  localparam int ST_FLAGS = 4;

  localparam logic ADDR_CMD_DATA    = 1'b0;
  localparam logic ADDR_CTRL_STATUS = 1'b1;
endpackage

// File: rtl/cmb_reset_ctrl.sv
module cmb_reset_ctrl #(
  parameter int unsigned FAULT_CYCLES = 100_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_req,
  output logic rst_sync_n,
  output logic soft_q,
  output logic stretch
);
  localparam int CNT_W = $clog2(FAULT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(FAULT_CYCLES);

  logic [1:0]       sync_q;
  logic             soft_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  // assert asynchronously, release on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_sync_n = sync_q[1];

  always_comb begin
    soft_d = 1'b0;
    cnt_d  = cnt_q;
    if (soft_q) begin
      cnt_d = CNT_LOAD;
    end else begin
      soft_d = soft_req;
      if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      soft_q <= 1'b0;
      cnt_q  <= CNT_LOAD;
    end else begin
      soft_q <= soft_d;
      cnt_q  <= cnt_d;
    end
  end

  assign stretch = (cnt_q != '0);
endmodule

// File: rtl/cmb_cmd_slot.sv
module cmb_cmd_slot #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              open,
  input  logic              core_ready,
  output logic              full,
  output logic [DATA_W-1:0] byte_q,
  output logic              overrun
);
  logic              full_d, ovr_d;
  logic [DATA_W-1:0] byte_d;

  always_comb begin
    full_d = full;
    byte_d = byte_q;
    ovr_d  = overrun;
    if (clr) begin
      full_d = 1'b0;
      byte_d = '0;
      ovr_d  = 1'b0;
    end else begin
      if (full && core_ready) full_d = 1'b0;
      if (wr_en) begin
        if (open) begin
          full_d = 1'b1;
          byte_d = wr_byte;
        end else begin
          ovr_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full    <= 1'b0;
      byte_q  <= '0;
      overrun <= 1'b0;
    end else begin
      full    <= full_d;
      byte_q  <= byte_d;
      overrun <= ovr_d;
    end
  end
endmodule

// File: rtl/cmb_res_slot.sv
module cmb_res_slot #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              push,
  input  logic [DATA_W-1:0] push_byte,
  input  logic              host_take,
  output logic              full,
  output logic [DATA_W-1:0] byte_q
);
  logic              full_d;
  logic [DATA_W-1:0] byte_d;

  always_comb begin
    full_d = full;
    byte_d = byte_q;
    if (clr) begin
      full_d = 1'b0;
      byte_d = '0;
    end else begin
      if (host_take) full_d = 1'b0;
      if (push && !full) begin
        full_d = 1'b1;
        byte_d = push_byte;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full   <= 1'b0;
      byte_q <= '0;
    end else begin
      full   <= full_d;
      byte_q <= byte_d;
    end
  end
endmodule

// File: rtl/cmb_alarm_latch.sv
module cmb_alarm_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic hit,
  input  logic ack,
  output logic alarm
);
  logic alarm_d;

  // a fresh violation outranks the acknowledge
  always_comb begin
    if (clr) alarm_d = 1'b0;
    else     alarm_d = hit | (alarm & ~ack);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alarm <= 1'b0;
    else        alarm <= alarm_d;
  end
endmodule

// File: rtl/cop_mailbox.sv
module cop_mailbox
  import cop_mailbox_pkg::*;
#(
  parameter int          DATA_W       = 8,
  parameter int unsigned FAULT_CYCLES = 100_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              cmd_valid,
  output logic [DATA_W-1:0] cmd_byte,
  input  logic              cmd_ready,
  input  logic              res_valid,
  input  logic [DATA_W-1:0] res_byte,
  output logic              res_ready,
  input  logic              alarm_hit,
  input  logic              alarm_clear,
  input  logic              fault_in,
  output logic              fault_led,
  output logic              overrun
);
  localparam int PAD_W = DATA_W - ST_FLAGS;

  logic              rst_sync_n, soft_q, stretch;
  logic              cmd_wr, ctrl_wr, data_rd;
  logic              cmd_full, dav_raw, alarm_raw, fault, crmt_vis;
  logic [DATA_W-1:0] data_byte;
  logic [DATA_W-1:0] status_word;

  assign cmd_wr  = host_wr && (host_addr == ADDR_CMD_DATA);
  assign ctrl_wr = host_wr && (host_addr == ADDR_CTRL_STATUS);
  assign data_rd = host_rd && (host_addr == ADDR_CMD_DATA);

  cmb_reset_ctrl #(.FAULT_CYCLES(FAULT_CYCLES)) u_rst (
    .clk(clk), .rst_n(rst_n), .soft_req(ctrl_wr),
    .rst_sync_n(rst_sync_n), .soft_q(soft_q), .stretch(stretch)
  );

  assign fault    = ~rst_sync_n | soft_q | stretch | fault_in;
  assign crmt_vis = ~cmd_full & ~fault;

  cmb_cmd_slot #(.DATA_W(DATA_W)) u_cmd (
    .clk(clk), .rst_n(rst_sync_n), .clr(soft_q),
    .wr_en(cmd_wr), .wr_byte(host_wdata), .open(crmt_vis),
    .core_ready(cmd_ready), .full(cmd_full), .byte_q(cmd_byte),
    .overrun(overrun)
  );

  cmb_res_slot #(.DATA_W(DATA_W)) u_res (
    .clk(clk), .rst_n(rst_sync_n), .clr(soft_q),
    .push(res_valid), .push_byte(res_byte), .host_take(data_rd),
    .full(dav_raw), .byte_q(data_byte)
  );

  cmb_alarm_latch u_alarm (
    .clk(clk), .rst_n(rst_sync_n), .clr(soft_q),
    .hit(alarm_hit), .ack(alarm_clear), .alarm(alarm_raw)
  );

  always_comb begin
    status_word           = '0;
    status_word[ST_CRMT]  = crmt_vis;
    status_word[ST_DAV]   = dav_raw & ~fault;
    status_word[ST_ALARM] = alarm_raw & ~fault;
    status_word[ST_FAULT] = fault;
  end

  assign host_rdata = (host_addr == ADDR_CTRL_STATUS) ? status_word : data_byte;
  assign cmd_valid  = cmd_full;
  assign res_ready  = ~dav_raw;
  assign fault_led  = fault;

  if (PAD_W < 0) begin : g_bad_width
    initial $error("DATA_W must hold the status flags");
  end
endmodule

// File: rtl/cop_mailbox_chk.sv
module cop_mailbox_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              soft_q,
  input logic              host_addr,
  input logic              host_wr,
  input logic [DATA_W-1:0] host_rdata,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [DATA_W-1:0] cmd_byte,
  input logic              res_valid,
  input logic              res_ready,
  input logic              dav_raw,
  input logic              alarm_raw,
  input logic              alarm_hit,
  input logic              alarm_clear,
  input logic              fault_led,
  input logic              overrun
);
  assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    host_addr |-> (host_rdata[DATA_W-1:4] == '0));

  assert_soft_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr) |=> fault_led);

  assert_cmd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n || soft_q)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_byte)));

  assert_res_take_R5: assert property (@(posedge clk) disable iff (!rst_n || soft_q)
    (res_valid && res_ready) |=> dav_raw);

  assert_alarm_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n || soft_q)
    (alarm_raw && !alarm_clear) |=> alarm_raw);

  assert_alarm_set_R6: assert property (@(posedge clk) disable iff (!rst_n || soft_q)
    alarm_hit |=> alarm_raw);

  assert_fault_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_led && host_addr) |-> (host_rdata[2:0] == 3'b000));

  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n || soft_q)
    overrun |=> overrun);
endmodule

bind cop_mailbox cop_mailbox_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_q(soft_q), .host_addr(host_addr),
  .host_wr(host_wr), .host_rdata(host_rdata), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .cmd_byte(cmd_byte), .res_valid(res_valid),
  .res_ready(res_ready), .dav_raw(dav_raw), .alarm_raw(alarm_raw),
  .alarm_hit(alarm_hit), .alarm_clear(alarm_clear), .fault_led(fault_led),
  .overrun(overrun)
);

// File: tb/cop_mailbox_bench.sv
`timescale 1ns/1ps
module cop_mailbox_bench;
  localparam int N = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       host_addr, host_wr, host_rd;
  logic [7:0] host_wdata, host_rdata;
  logic       cmd_valid, cmd_ready;
  logic [7:0] cmd_byte;
  logic       res_valid, res_ready;
  logic [7:0] res_byte;
  logic       alarm_hit, alarm_clear, fault_in, fault_led, overrun;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  cop_mailbox #(.DATA_W(8), .FAULT_CYCLES(N)) u_cop_mailbox (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .cmd_ready(cmd_ready),
    .res_valid(res_valid), .res_byte(res_byte), .res_ready(res_ready),
    .alarm_hit(alarm_hit), .alarm_clear(alarm_clear), .fault_in(fault_in),
    .fault_led(fault_led), .overrun(overrun)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic read_status(output logic [7:0] s);
    host_addr = 1'b1;
    #0.5 s = host_rdata;
  endtask

  task automatic host_write(input logic a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic count_fault(input string req);
    int k = 1;
    while (fault_led && k < 4 * N) begin
      @(negedge clk);
      k++;
    end
    check(req, k, N + 2);
  endtask

  task automatic t_reset;
    logic [7:0] s;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    read_status(s);
    check("R1 status in reset", s, 8'h08);
    check("R1 cmd_valid in reset", cmd_valid, 0);
    check("R1 overrun in reset", overrun, 0);
    rst_n = 1'b1;
    @(negedge clk);
    count_fault("R2 hard fault window");
    read_status(s);
    check("R2 status after window", s, 8'h01);
    check("R2 fault_led mirror", fault_led, s[3]);
  endtask

  task automatic t_command;
    logic [7:0] s;
    host_write(1'b0, 8'hA5);
    read_status(s);
    check("R4 crmt clear", s, 8'h00);
    check("R4 cmd_valid", cmd_valid, 1);
    check("R4 cmd_byte", cmd_byte, 8'hA5);
    repeat (3) @(negedge clk);
    check("R4 held without ready", {cmd_valid, cmd_byte}, {1'b1, 8'hA5});
    cmd_ready = 1'b1;
    @(negedge clk);
    cmd_ready = 1'b0;
    read_status(s);
    check("R4 taken", cmd_valid, 0);
    check("R4 crmt back", s, 8'h01);
  endtask

  task automatic t_overrun;
    host_write(1'b0, 8'h11);
    check("R8 no overrun yet", overrun, 0);
    host_write(1'b0, 8'h22);
    check("R8 byte kept", cmd_byte, 8'h11);
    check("R8 overrun set", overrun, 1);
    cmd_ready = 1'b1;
    @(negedge clk);
    cmd_ready = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 overrun sticky", overrun, 1);
  endtask

  task automatic t_result;
    logic [7:0] s;
    check("R5 ready when empty", res_ready, 1);
    @(negedge clk);
    res_valid = 1'b1; res_byte = 8'h3C;
    @(negedge clk);
    res_byte = 8'h77;
    read_status(s);
    check("R5 dav set", s, 8'h03);
    check("R5 ready low", res_ready, 0);
    @(negedge clk);
    res_valid = 1'b0;
    host_addr = 1'b0; host_rd = 1'b1;
    #0.5 check("R5 read byte", host_rdata, 8'h3C);
    @(negedge clk);
    host_rd = 1'b0;
    read_status(s);
    check("R5 dav cleared", s, 8'h01);
    check("R5 ready again", res_ready, 1);
  endtask

  task automatic t_alarm;
    logic [7:0] s;
    @(negedge clk);
    alarm_hit = 1'b1;
    @(negedge clk);
    alarm_hit = 1'b0;
    repeat (3) @(negedge clk);
    read_status(s);
    check("R6 alarm sticky through reads", s, 8'h05);
    alarm_hit = 1'b1; alarm_clear = 1'b1;
    @(negedge clk);
    alarm_hit = 1'b0; alarm_clear = 1'b0;
    read_status(s);
    check("R6 hit beats clear", s, 8'h05);
    alarm_clear = 1'b1;
    @(negedge clk);
    alarm_clear = 1'b0;
    read_status(s);
    check("R6 cleared", s, 8'h01);
  endtask

  task automatic t_mask_and_soft;
    logic [7:0] s;
    @(negedge clk);
    alarm_hit = 1'b1; res_valid = 1'b1; res_byte = 8'h5E;
    @(negedge clk);
    alarm_hit = 1'b0; res_valid = 1'b0;
    fault_in = 1'b1;
    read_status(s);
    check("R7 masked by fault_in", s, 8'h08);
    check("R7 fault_led", fault_led, 1);
    @(negedge clk);
    fault_in = 1'b0;
    read_status(s);
    check("R7 flags back", s, 8'h07);
    host_write(1'b0, 8'h99);
    check("R3 pre cmd pending", cmd_valid, 1);
    @(negedge clk);
    host_addr = 1'b1; host_wdata = 8'h5A; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
    read_status(s);
    check("R3 fault on soft reset", s, 8'h08);
    count_fault("R3 soft fault window");
    read_status(s);
    check("R3 status after soft", s, 8'h01);
    check("R3 cmd cleared", cmd_valid, 0);
    check("R3 overrun cleared", overrun, 0);
    host_addr = 1'b0;
    #0.5 check("R3 data cleared", host_rdata, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; host_addr = 1'b0; host_wr = 1'b0; host_rd = 1'b0;
    host_wdata = '0; cmd_ready = 1'b0; res_valid = 1'b0; res_byte = '0;
    alarm_hit = 1'b0; alarm_clear = 1'b0; fault_in = 1'b0;
    t_reset();
    t_command();
    t_overrun();
    t_result();
    t_alarm();
    t_mask_and_soft();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule